// File: doc/BRIEF.md
# Single-Line Half-Duplex Serial Master

This block is a serial master that talks to a peripheral over one shared, bidirectional data line plus a clock output. The clock idles low; the master launches each outgoing bit while the clock is low and captures each incoming bit on the low-to-high clock transition. A host loads up to four outgoing words into a transmit queue, selects a word width of 8, 16 or 32 bits, a bit order and a clock divider, and pulses `start` with a count of words to send and a count of words to fetch.

A transaction always runs the send part first, with the pad driven, then releases the pad and runs the fetch part. Any part whose count is zero is skipped. Received bits are packed into words of the selected width and placed in a four-word receive queue, which the host drains through a show-ahead pop port. The engine stretches the low half of the clock whenever it must wait for the host: it waits when the transmit queue runs dry before the last word is sent, and when the receive queue is full. A one-cycle `done` marks the end of the transaction. A start with an unsupported word width or divider is refused and flagged.

Top module: `sio3_master`

## Requirements
- R1: After reset `sclk` and `sio_out` are 0, `sio_oe` is 1, and `busy`, `done` and `cfg_err` are 0; whenever `busy` is 0, `sclk` is 0 and `sio_oe` is 1.
- R2: `sio_out` only changes while `sclk` is low (it holds steady across every high half), and `sio_in` is captured on the system edge that takes `sclk` high.
- R3: With divider value D (`clk_div`, legal range 1 to 65536), each half of a serial clock period lasts D system cycles, so consecutive rising edges of `sclk` are 2·D system cycles apart while data flows.
- R4: A `start` with `word_bits` other than 8, 16 or 32, or with `clk_div` of 0 or above 65536, raises `cfg_err` for one cycle on the next edge and leaves `busy` low.
- R5: With `lsb_first`=0 a sent word goes out from bit `word_bits`−1 down to bit 0; with `lsb_first`=1 it goes out from bit 0 upward.
- R6: Queued send words follow each other without a gap in the clock; when the transmit queue is empty but words remain to be sent, `sclk` stays low and the pad stays driven until a word arrives.
- R7: `sio_oe` is 1 for the whole send part and 0 for the whole fetch part; it is 0 only while `busy` is 1.
- R8: A fetch of N words produces exactly N·`word_bits` rising edges of `sclk` with `sio_oe`=0, and each word appears on `rx_rdata` packed in the selected bit order (first bit received lands in bit `word_bits`−1 when `lsb_first`=0, in bit 0 when `lsb_first`=1); both queues are emptied as the fetch part begins.
- R9: When both counts are nonzero, every send bit is clocked before the first fetch bit.
- R10: A part with a zero count is skipped; with both counts zero the block produces no `sclk` edge and still pulses `done`.
- R11: A `start` while `busy` is 1 has no effect on the transaction in progress and starts nothing afterwards.
- R12: `done` is high for exactly one cycle after the last part ends, and `sclk` is low whenever `done` is high.
- R13: During the fetch part, while the receive queue holds four words, `sclk` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a transaction |
| word_bits | input | 6 | Word width in bits: 8, 16 or 32 |
| lsb_first | input | 1 | 1 sends and packs bit 0 first, 0 sends the top bit first |
| clk_div | input | 17 | System cycles per serial clock half, 1 to 65536 |
| wr_words | input | 16 | Number of words to send |
| rd_words | input | 16 | Number of words to fetch |
| tx_push | input | 1 | Write `tx_wdata` into the transmit queue |
| tx_wdata | input | 32 | Outgoing word, right-aligned |
| tx_full | output | 1 | Transmit queue holds four words |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_rdata | output | 32 | Head of the receive queue, right-aligned |
| rx_empty | output | 1 | Receive queue holds no word |
| sclk | output | 1 | Serial clock, idles low |
| sio_out | output | 1 | Value driven onto the shared data line |
| sio_oe | output | 1 | 1 when the master drives the data line |
| sio_in | input | 1 | Value seen on the shared data line |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| cfg_err | output | 1 | One-cycle pulse when a start is refused |

## Verification
Every cycle the assertions hold the data line steady across high clock halves, keep the pad released only inside a transaction, keep `done` a single clock-low pulse, hold the clock low while the receive queue is full, and keep a refused start from raising `busy`. Bit order, word packing, the exact clock period set by the divider, the absence of a gap between queued words, the send-before-fetch ordering, skipped zero-length parts and an ignored mid-transaction start are only visible through the bench's scenarios, where a slave model feeds the line and a scoreboard compares every word sent and fetched.

// File: rtl/sio3_pkg.sv
package sio3_pkg;
  parameter int DW    = 32;             // widest word
  parameter int SZ_W  = $clog2(DW) + 1; // holds the value DW
  parameter int CNT_W = 16;             // word counts
  parameter int DIV_W = 17;             // divider, up to 2**(DIV_W-1)
  parameter int RB_W  = CNT_W + SZ_W;   // total fetch bits

  typedef enum logic [2:0] {
    PH_IDLE, PH_WR_WAIT, PH_WR_LO, PH_WR_HI,
    PH_RD_PREP, PH_RD_LO, PH_RD_HI, PH_FIN
  } phase_e;

  function automatic logic size_ok(logic [SZ_W-1:0] w);
    return (w == SZ_W'(8)) || (w == SZ_W'(16)) || (w == SZ_W'(32));
  endfunction

  function automatic logic div_ok(logic [DIV_W-1:0] d);
    return (d != '0) && (d <= (DIV_W'(1) << (DIV_W - 1)));
  endfunction

  // Place the word so the first bit to send sits at bit 0 or bit DW-1.
  function automatic logic [DW-1:0] align_tx(logic [DW-1:0] d, logic [SZ_W-1:0] w,
                                             logic lsb);
    return lsb ? d : (d << (SZ_W'(DW) - w));
  endfunction

  // Right-align a collected word.
  function automatic logic [DW-1:0] rx_finish(logic [DW-1:0] acc, logic [SZ_W-1:0] w,
                                              logic lsb);
    logic [DW-1:0] m;
    m = (w == SZ_W'(DW)) ? '1 : ((DW'(1) << w) - DW'(1));
    return lsb ? (acc >> (SZ_W'(DW) - w)) : (acc & m);
  endfunction

  // Bit counter preload for a fetch: words times width, minus one.
  function automatic logic [RB_W-1:0] read_bits(logic [CNT_W-1:0] n, logic [SZ_W-1:0] w);
    logic [RB_W-1:0] p;
    p = RB_W'(n) * RB_W'(w);
    return p - RB_W'(1);
  endfunction
endpackage

// File: rtl/sio3_fifo.sv
module sio3_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= din;
  end
endmodule

// File: rtl/sio3_engine.sv
module sio3_engine
  import sio3_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SZ_W-1:0]  word_bits,
  input  logic             lsb_first,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [CNT_W-1:0] wr_words,
  input  logic [CNT_W-1:0] rd_words,
  input  logic             tx_empty,
  input  logic [DW-1:0]    tx_data,
  output logic             tx_pop,
  input  logic             rx_full,
  output logic             rx_push,
  output logic [DW-1:0]    rx_data,
  output logic             fifo_clr,
  output logic             sclk,
  output logic             sio_out,
  output logic             sio_oe,
  input  logic             sio_in,
  output logic             busy,
  output logic             done,
  output logic             cfg_err
);
  phase_e           ph;
  logic [SZ_W-1:0]  wsz;
  logic             lsb;
  logic [DIV_W-1:0] div_m1, cnt;
  logic [CNT_W-1:0] wr_left, rd_req;
  logic [RB_W-1:0]  rd_cnt;
  logic [SZ_W-1:0]  bit_left, wbits;
  logic [DW-1:0]    shreg, acc;

  // Named internal events
  logic             half_end, word_last, rx_edge;
  logic [DW-1:0]    ld_word, sh_next, acc_next;
  logic [SZ_W-1:0]  wsz_dec;

  assign half_end  = (cnt == '0);
  assign wsz_dec   = wsz - SZ_W'(1);
  assign word_last = (bit_left == '0);
  assign ld_word   = align_tx(tx_data, wsz, lsb);
  assign sh_next   = lsb ? (shreg >> 1) : (shreg << 1);
  assign acc_next  = lsb ? {sio_in, acc[DW-1:1]} : {acc[DW-2:0], sio_in};
  assign rx_edge   = (ph == PH_RD_LO) && half_end && !rx_full;

  assign tx_pop    = !tx_empty && ((ph == PH_WR_WAIT) ||
                     ((ph == PH_WR_HI) && half_end && word_last && (wr_left != '0)));
  assign rx_push   = rx_edge && (wbits == wsz_dec);
  assign rx_data   = rx_finish(acc_next, wsz, lsb);
  assign fifo_clr  = (ph == PH_RD_PREP);
  assign busy      = (ph != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; wsz <= SZ_W'(8); lsb <= 1'b0;
      div_m1 <= '0; cnt <= '0; wr_left <= '0; rd_req <= '0; rd_cnt <= '0;
      bit_left <= '0; wbits <= '0; shreg <= '0; acc <= '0;
      sclk <= 1'b0; sio_out <= 1'b0; sio_oe <= 1'b1; done <= 1'b0; cfg_err <= 1'b0;
    end else begin
      done    <= 1'b0;
      cfg_err <= 1'b0;
      if (tx_pop) begin
        shreg    <= ld_word;
        sio_out  <= lsb ? ld_word[0] : ld_word[DW-1];
        bit_left <= wsz_dec;
        wr_left  <= wr_left - CNT_W'(1);
        cnt      <= div_m1;
        ph       <= PH_WR_LO;
      end
      unique case (ph)
        PH_IDLE: if (start) begin
          if (!size_ok(word_bits) || !div_ok(clk_div)) begin
            cfg_err <= 1'b1;
          end else begin
            wsz     <= word_bits;
            lsb     <= lsb_first;
            div_m1  <= clk_div - DIV_W'(1);
            wr_left <= wr_words;
            rd_req  <= rd_words;
            ph <= (wr_words != '0) ? PH_WR_WAIT :
                  (rd_words != '0) ? PH_RD_PREP : PH_FIN;
          end
        end
        PH_WR_WAIT: ;  // clock held low until tx_pop
        PH_WR_LO: if (half_end) begin
          sclk <= 1'b1; cnt <= div_m1; ph <= PH_WR_HI;
        end else cnt <= cnt - DIV_W'(1);
        PH_WR_HI: if (half_end) begin
          sclk <= 1'b0;
          if (!word_last) begin
            shreg    <= sh_next;
            sio_out  <= lsb ? sh_next[0] : sh_next[DW-1];
            bit_left <= bit_left - SZ_W'(1);
            cnt      <= div_m1;
            ph       <= PH_WR_LO;
          end else if (wr_left != '0) begin
            if (!tx_pop) ph <= PH_WR_WAIT;
          end else begin
            sio_out <= 1'b0;
            ph <= (rd_req != '0) ? PH_RD_PREP : PH_FIN;
          end
        end else cnt <= cnt - DIV_W'(1);
        PH_RD_PREP: begin
          sio_oe <= 1'b0;
          rd_cnt <= read_bits(rd_req, wsz);
          wbits  <= '0;
          acc    <= '0;
          cnt    <= div_m1;
          ph     <= PH_RD_LO;
        end
        PH_RD_LO: if (half_end) begin
          if (!rx_full) begin
            sclk  <= 1'b1;
            acc   <= acc_next;
            wbits <= (wbits == wsz_dec) ? '0 : wbits + SZ_W'(1);
            cnt   <= div_m1;
            ph    <= PH_RD_HI;
          end
        end else cnt <= cnt - DIV_W'(1);
        PH_RD_HI: if (half_end) begin
          sclk <= 1'b0;
          if (rd_cnt == '0) ph <= PH_FIN;
          else begin
            rd_cnt <= rd_cnt - RB_W'(1);
            cnt    <= div_m1;
            ph     <= PH_RD_LO;
          end
        end else cnt <= cnt - DIV_W'(1);
        PH_FIN: begin
          sio_oe <= 1'b1;
          done   <= 1'b1;
          ph     <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sio3_master.sv
module sio3_master
  import sio3_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SZ_W-1:0]  word_bits,
  input  logic             lsb_first,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [CNT_W-1:0] wr_words,
  input  logic [CNT_W-1:0] rd_words,
  input  logic             tx_push,
  input  logic [DW-1:0]    tx_wdata,
  output logic             tx_full,
  input  logic             rx_pop,
  output logic [DW-1:0]    rx_rdata,
  output logic             rx_empty,
  output logic             sclk,
  output logic             sio_out,
  output logic             sio_oe,
  input  logic             sio_in,
  output logic             busy,
  output logic             done,
  output logic             cfg_err
);
  logic          tx_empty, tx_pop, rx_full, rx_push, fifo_clr;
  logic [DW-1:0] tx_head, rx_word;

  sio3_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
    .push(tx_push), .din(tx_wdata), .pop(tx_pop), .dout(tx_head),
    .empty(tx_empty), .full(tx_full)
  );

  sio3_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
    .push(rx_push), .din(rx_word), .pop(rx_pop), .dout(rx_rdata),
    .empty(rx_empty), .full(rx_full)
  );

  sio3_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(start),
    .word_bits(word_bits), .lsb_first(lsb_first), .clk_div(clk_div),
    .wr_words(wr_words), .rd_words(rd_words),
    .tx_empty(tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
    .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_word),
    .fifo_clr(fifo_clr), .sclk(sclk), .sio_out(sio_out), .sio_oe(sio_oe),
    .sio_in(sio_in), .busy(busy), .done(done), .cfg_err(cfg_err)
  );
endmodule

// File: rtl/sio3_checker.sv
module sio3_checker (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic sio_out,
  input logic sio_oe,
  input logic busy,
  input logic done,
  input logic cfg_err,
  input logic rx_full
);
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && sio_oe)); // R1

  AST_OUT_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sio_out)); // R2

  AST_REFUSED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy); // R4

  AST_PAD_RELEASE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !sio_oe |-> busy); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12

  AST_DONE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !sclk); // R12

  AST_RX_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sio_oe && !sclk && rx_full) |=> !sclk); // R13
endmodule

bind sio3_master sio3_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .sio_out(sio_out), .sio_oe(sio_oe),
  .busy(busy), .done(done), .cfg_err(cfg_err), .rx_full(rx_full)
);

// File: tb/test_sio3_master.sv
`timescale 1ns/1ps
module test_sio3_master;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, lsb_first = 1'b0;
  logic [5:0]  word_bits = 6'd8;
  logic [16:0] clk_div = 17'd1;
  logic [15:0] wr_words = '0, rd_words = '0;
  logic        tx_push = 1'b0, rx_pop = 1'b0, sio_in = 1'b0;
  logic [31:0] tx_wdata = '0;
  logic        tx_full, rx_empty, sclk, sio_out, sio_oe, busy, done, cfg_err;
  logic [31:0] rx_rdata;

  always #4 clk = ~clk;

  sio3_master i_sio3_master (.*);

  int total = 0, bad = 0;
  logic [31:0] exp_tx[$], exp_rx[$];
  bit          sbits[$];
  int          cur_wsz = 8;
  bit          cur_lsb = 0;
  int          tx_words = 0, rd_edges = 0, order_bad = 0;
  logic [31:0] mon_w = '0;
  int          mon_n = 0;
  bit          per_en = 0, have_prev = 0;
  realtime     prev_t = 0, exp_per = 0;
  int          per_n = 0, per_err = 0;
  bit          prev_done = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] msk(logic [31:0] d, int wb);
    return (wb == 32) ? d : (d & ((32'd1 << wb) - 1));
  endfunction

  // Scoreboard: sent-word monitor
  always @(posedge sclk) begin
    if (sio_oe) begin
      if (cur_lsb) mon_w[mon_n] = sio_out;
      else mon_w = {mon_w[30:0], sio_out};
      mon_n++;
      if (mon_n == cur_wsz) begin
        logic [31:0] e;
        e = (exp_tx.size() > 0) ? exp_tx.pop_front() : 32'hdead;
        chk(msk(mon_w, cur_wsz) == e, "R5 sent word", msk(mon_w, cur_wsz), e);
        tx_words++;
        mon_n = 0; mon_w = '0;
      end
    end else begin
      rd_edges++;
      if (exp_tx.size() != 0) order_bad++;
    end
    if (per_en) begin
      if (have_prev) begin
        per_n++;
        if ($realtime - prev_t != exp_per) per_err++;
      end
      have_prev = 1;
      prev_t = $realtime;
    end
  end

  // Slave model: next bit whenever the clock falls or the pad is released
  always @(negedge sclk or negedge sio_oe) begin
    if (!sio_oe && sbits.size() > 0) sio_in = sbits.pop_front();
  end

  always @(negedge clk) begin
    if (rst_n && done) chk(!prev_done && !sclk, "R12 done pulse", {prev_done, sclk}, 0);
    prev_done = done;
  end

  task automatic start_op(int wb, bit lsb, int dv, int nw, int nr);
    @(negedge clk);
    word_bits = 6'(wb); lsb_first = lsb; clk_div = 17'(dv);
    wr_words = 16'(nw); rd_words = 16'(nr); start = 1'b1;
    if (wb == 8 || wb == 16 || wb == 32) begin cur_wsz = wb; cur_lsb = lsb; end
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 50000) begin @(negedge clk); t++; end
    chk(t < 50000, "R12 done seen", t, 0);
  endtask

  task automatic push_tx(logic [31:0] d, int wb);
    @(negedge clk);
    tx_push = 1'b1; tx_wdata = d;
    exp_tx.push_back(msk(d, wb));
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic add_rx(logic [31:0] d, int wb, bit lsb);
    logic [31:0] m;
    m = msk(d, wb);
    exp_rx.push_back(m);
    for (int i = 0; i < wb; i++) sbits.push_back(lsb ? m[i] : m[wb-1-i]);
  endtask

  task automatic pop_chk(string tag);
    int t = 0;
    logic [31:0] e;
    while (rx_empty && t < 20000) begin @(negedge clk); t++; end
    e = (exp_rx.size() > 0) ? exp_rx.pop_front() : 32'hdead;
    chk(!rx_empty && rx_rdata == e, tag, rx_rdata, e);
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!sclk && !sio_out && sio_oe, "R1 lines at reset", {sclk, sio_out, sio_oe}, 3'b001);
    chk(!busy && !done && !cfg_err, "R1 status at reset", {busy, done, cfg_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 refused configurations
    start_op(12, 0, 1, 1, 0);
    chk(cfg_err && !busy, "R4 bad width", {cfg_err, busy}, 2'b10);
    start_op(8, 0, 0, 1, 0);
    chk(cfg_err && !busy, "R4 zero divider", {cfg_err, busy}, 2'b10);
    start_op(16, 0, 65537, 1, 0);
    chk(cfg_err && !busy, "R4 divider too big", {cfg_err, busy}, 2'b10);
    @(negedge clk);
    chk(!cfg_err && !busy, "R4 flag one cycle", {cfg_err, busy}, 0);

    // R3 R6 divider 3, two 8-bit words MSB first, no gap between words
    push_tx(32'hA5, 8); push_tx(32'h3C, 8);
    per_en = 1; have_prev = 0; per_n = 0; per_err = 0; exp_per = 48;
    start_op(8, 0, 3, 2, 0);
    chk(busy, "R3 started", busy, 1);
    wait_done();
    per_en = 0;
    chk(per_err == 0 && per_n == 15, "R3 R6 clock period", per_err * 100 + per_n, 15);
    chk(exp_tx.size() == 0, "R5 msb words all sent", exp_tx.size(), 0);

    // R5 LSB first, 16-bit, divider 2
    push_tx(32'h1234_8001, 16); push_tx(32'h0000_C3A6, 16);
    start_op(16, 1, 2, 2, 0);
    wait_done();
    chk(exp_tx.size() == 0, "R5 lsb words all sent", exp_tx.size(), 0);

    // R6 stall on empty transmit queue
    push_tx(32'h5A, 8);
    start_op(8, 0, 1, 3, 0);
    repeat (60) @(negedge clk);
    chk(busy && !sclk && sio_oe, "R6 hold while queue empty", {busy, sclk, sio_oe}, 3'b101);
    push_tx(32'hF0, 8); push_tx(32'h0F, 8);
    wait_done();
    chk(exp_tx.size() == 0, "R6 resumed words", exp_tx.size(), 0);

    // R8 R2 fetch three 8-bit words MSB first
    add_rx(32'hC5, 8, 0); add_rx(32'h01, 8, 0); add_rx(32'h80, 8, 0);
    rd_edges = 0;
    start_op(8, 0, 1, 0, 3);
    wait_done();
    chk(rd_edges == 24, "R8 fetch edges", rd_edges, 24);
    for (int i = 0; i < 3; i++) pop_chk("R8 R2 fetched msb word");

    // R8 fetch two 32-bit words LSB first
    add_rx(32'hDEAD_BEEF, 32, 1); add_rx(32'h8000_0001, 32, 1);
    rd_edges = 0;
    start_op(32, 1, 2, 0, 2);
    wait_done();
    chk(rd_edges == 64, "R8 fetch edges 32", rd_edges, 64);
    for (int i = 0; i < 2; i++) pop_chk("R8 fetched lsb word");

    // R9 R7 send then fetch
    push_tx(32'hBEEF, 16); push_tx(32'h0123, 16);
    add_rx(32'h7E81, 16, 0); add_rx(32'hFFFE, 16, 0);
    rd_edges = 0; order_bad = 0;
    start_op(16, 0, 1, 2, 2);
    wait_done();
    chk(order_bad == 0 && exp_tx.size() == 0, "R9 send before fetch", order_bad, 0);
    chk(rd_edges == 32, "R7 R9 fetch edges", rd_edges, 32);
    for (int i = 0; i < 2; i++) pop_chk("R9 fetched word");

    // R10 both counts zero
    rd_edges = 0; tx_words = 0;
    start_op(8, 0, 1, 0, 0);
    wait_done();
    chk(rd_edges == 0 && tx_words == 0, "R10 no clock edges", rd_edges + tx_words, 0);

    // R11 start while busy
    push_tx(32'h11, 8); push_tx(32'h22, 8);
    tx_words = 0;
    start_op(8, 0, 4, 2, 0);
    repeat (20) @(negedge clk);
    start_op(8, 0, 1, 5, 3);
    wait_done();
    repeat (100) @(negedge clk);
    chk(!busy && tx_words == 2, "R11 second start ignored", tx_words, 2);
    chk(exp_tx.size() == 0, "R11 queue drained", exp_tx.size(), 0);

    // R13 stall on full receive queue
    for (int i = 0; i < 6; i++) add_rx(32'(8'h31 + i * 8'h17), 8, 0);
    rd_edges = 0;
    start_op(8, 0, 1, 0, 6);
    repeat (300) @(negedge clk);
    chk(busy && !sclk && !sio_oe, "R13 hold while full", {busy, sclk, sio_oe}, 3'b100);
    chk(rd_edges == 32, "R13 edges before stall", rd_edges, 32);
    for (int i = 0; i < 6; i++) pop_chk("R13 fetched word");
    wait_done();
    chk(rd_edges == 48, "R13 total edges", rd_edges, 48);

    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule